// File: doc/BRIEF.md
# Shared-Address Serial Data Buffer

This block puts a transmit shifter and a receive shifter behind one register address. A write to the data address loads the transmit shifter in parallel and starts a serial frame on the TX line. A read from the same address returns the last byte that the receive shifter assembled from the RX line. A second address holds the two completion flags. Software polls these flags and clears them.

Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. Bit timing comes from an external oversampling tick. One bit lasts sixteen ticks. The receiver uses the same tick to find the centre of each bit. The transmit flag sets when the stop bit ends. The receive flag sets when a byte is accepted. While the receive flag is set, the receive register is protected and later bytes are dropped.

Top module: `ser_buf_top`

## Requirements
- R1: After reset the TX line is high, both flags are 0 and a read at address 0 returns 0.
- R2: A write at address 0 while no frame is in progress starts a frame on TX. The frame is a low start bit, the eight written bits least significant first, and a high stop bit. Each bit lasts 16 os_tick pulses. TX is high whenever no frame is in progress.
- R3: The transmit flag (status bit 0) is 0 during the whole frame, including the stop bit. It becomes 1 when the stop bit ends.
- R4: A write at address 0 while a frame is in progress has no effect. The frame in progress keeps its data, and no second frame follows it.
- R5: The receiver reacts to a falling edge on RX and confirms the start bit 8 ticks later. It samples each data bit 16 ticks after the previous sample and checks that the stop bit is high. It then loads the byte into the receive register and sets the receive flag (status bit 1).
- R6: A low pulse on RX that is shorter than half a bit is not taken as a start bit. No byte is received and the receive flag stays 0.
- R7: A byte that completes while the receive flag is 1 is discarded, and the receive register keeps its earlier value.
- R8: A write at address 1 clears the transmit flag if data bit 0 is 1 and the receive flag if data bit 1 is 1. The flags change in no other way except by being set. A read at address 1 returns {0…, receive flag, transmit flag}.
- R9: A read at address 0 always returns the receive register, never the byte last written for transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = data buffer, 1 = flag register |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for bus_addr |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line |
| ti | output | 1 | Transmit-complete flag |
| ri | output | 1 | Receive-complete flag |

## Verification
The transmitter is tried with the bytes 0xA5, 0x01 and 0x80. These patterns tell a correct bit order from a reversed one and show whether the start and stop levels are right. A second write is issued mid-frame to show that the shifter is not reloaded. The receiver gets the bytes 0x5A, 0xC3 and 0x7E. The second arrives while the receive flag is still set, which separates the discard rule from an overwrite. A two-tick low glitch shows whether the receiver really confirms the start bit at mid-bit.

// File: rtl/ser_buf_pkg.sv
package ser_buf_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/sbuf_tx.sv
module sbuf_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              busy,
  output logic              done,
  output logic              tx_o
);
  localparam int FW  = DATA_W + 2;
  localparam int CW  = $clog2(OVS);
  localparam int BCW = $clog2(FW + 1);

  logic [FW-1:0]  sh_q, sh_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [BCW-1:0] bit_q, bit_d;
  logic           busy_q, busy_d;
  logic           en;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    done   = 1'b0;
    if (!busy_q) begin
      if (load) begin
        sh_d   = {1'b1, load_data, 1'b0};
        cnt_d  = '0;
        bit_d  = '0;
        busy_d = 1'b1;
      end
    end else if (os_tick) begin
      if (cnt_q == CW'(OVS - 1)) begin
        cnt_d = '0;
        sh_d  = {1'b1, sh_q[FW-1:1]};
        if (bit_q == BCW'(FW - 1)) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign en = busy_q ? os_tick : load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
    end else if (en) begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign tx_o = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/sbuf_rx.sv
module sbuf_rx
  import ser_buf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_i,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data
);
  localparam int CW  = $clog2(OVS);
  localparam int BCW = $clog2(DATA_W);
  localparam int MID = OVS / 2;

  logic [2:0]        sync_q;
  rx_state_e         st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BCW-1:0]    bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              rx_s, fall;

  assign rx_s = sync_q[1];
  assign fall = sync_q[2] & ~sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[1:0], rx_i};
  end

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    bit_d      = bit_q;
    sh_d       = sh_q;
    byte_valid = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        if (fall) begin
          st_d  = RX_START;
          cnt_d = '0;
        end
      end
      RX_START: begin
        if (os_tick) begin
          if (cnt_q == CW'(MID - 1)) begin
            cnt_d = '0;
            bit_d = '0;
            st_d  = rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (os_tick) begin
          if (cnt_q == CW'(OVS - 1)) begin
            cnt_d = '0;
            sh_d  = {rx_s, sh_q[DATA_W-1:1]};
            if (bit_q == BCW'(DATA_W - 1)) st_d = RX_STOP;
            else                           bit_d = bit_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (os_tick) begin
          if (cnt_q == CW'(OVS - 1)) begin
            cnt_d      = '0;
            st_d       = RX_IDLE;
            byte_valid = rx_s;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

  assign byte_data = sh_q;
endmodule

// File: rtl/ser_buf_top.sv
module ser_buf_top #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              tx_o,
  input  logic              rx_i,
  output logic              ti,
  output logic              ri
);
  logic              wr_buf, wr_flag;
  logic              tx_busy, tx_done;
  logic              rx_valid;
  logic [DATA_W-1:0] rx_byte;
  logic              ti_q, ti_d, ri_q, ri_d;
  logic [DATA_W-1:0] rxbuf_q, rxbuf_d;
  logic              rxbuf_en;

  assign wr_buf  = bus_wr & ~bus_addr;
  assign wr_flag = bus_wr &  bus_addr;

  sbuf_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
    .load(wr_buf), .load_data(bus_wdata),
    .busy(tx_busy), .done(tx_done), .tx_o(tx_o)
  );

  sbuf_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_i(rx_i),
    .byte_valid(rx_valid), .byte_data(rx_byte)
  );

  always_comb begin
    ti_d = ti_q;
    if (wr_flag && bus_wdata[0]) ti_d = 1'b0;
    if (tx_done)                 ti_d = 1'b1;
    ri_d     = ri_q;
    rxbuf_d  = rxbuf_q;
    rxbuf_en = rx_valid & ~ri_q;
    if (wr_flag && bus_wdata[1]) ri_d = 1'b0;
    if (rxbuf_en) begin
      ri_d    = 1'b1;
      rxbuf_d = rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ti_q <= 1'b0;
      ri_q <= 1'b0;
    end else begin
      ti_q <= ti_d;
      ri_q <= ri_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rxbuf_q <= '0;
    else if (rxbuf_en) rxbuf_q <= rxbuf_d;
  end

  assign rd_data = bus_addr ? {{(DATA_W-2){1'b0}}, ri_q, ti_q} : rxbuf_q;
  assign ti = ti_q;
  assign ri = ri_q;
endmodule

// File: rtl/ser_buf_chk.sv
module ser_buf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_o,
  input logic              tx_busy,
  input logic              ti,
  input logic              ri,
  input logic [DATA_W-1:0] rxbuf,
  input logic              bus_wr,
  input logic              bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);
  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_o);  // R2
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !tx_o);  // R2
  AST_TI_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti) |-> !tx_busy);  // R3
  AST_RXBUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ri && $past(ri)) |-> $stable(rxbuf));  // R7
  AST_RI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ri && !(bus_wr && bus_addr && bus_wdata[1])) |=> ri);  // R8
  AST_TI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ti && !(bus_wr && bus_addr && bus_wdata[0])) |=> ti);  // R8
endmodule

bind ser_buf_top ser_buf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_o(tx_o), .tx_busy(tx_busy),
  .ti(ti_q), .ri(ri_q), .rxbuf(rxbuf_q),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/test_ser_buf_top.sv
`timescale 1ns/1ps
module test_ser_buf_top;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic bus_wr = 1'b0;
  logic bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rd_data;
  logic tx_o;
  logic rx_i = 1'b1;
  logic ti, ri;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ser_buf_top i_ser_buf_top (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .tx_o(tx_o), .rx_i(rx_i), .ti(ti), .ri(ri)
  );

  initial begin
    forever begin
      for (int k = 0; k < TDIV; k++) begin
        @(negedge clk);
        os_tick = (k == 0);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = rd_data;
    bus_addr = 1'b0;
  endtask

  // Waits for the start bit, checks the whole frame; optional mid-frame write
  task automatic tx_frame(input logic [7:0] exp, input bit poke, input string tag);
    int guard = 0;
    while (tx_o !== 1'b0 && guard < 1000) begin @(negedge clk); guard++; end
    chk(tx_o === 1'b0, {tag, " start seen"}, tx_o, 0);
    repeat (BITC/2) @(negedge clk);
    chk(tx_o === 1'b0, {tag, " start bit"}, tx_o, 0);
    for (int b = 0; b < 8; b++) begin
      if (poke && b == 3) begin
        wr(1'b0, ~exp);
        repeat (BITC - 2) @(negedge clk);
      end else begin
        repeat (BITC) @(negedge clk);
      end
      chk(tx_o === exp[b], $sformatf("%s data bit %0d", tag, b), tx_o, exp[b]);
    end
    repeat (BITC) @(negedge clk);
    chk(tx_o === 1'b1, {tag, " stop bit"}, tx_o, 1);
    chk(ti === 1'b0, "R3 ti clear during stop", ti, 0);
    repeat (BITC/2 + 4) @(negedge clk);
    chk(ti === 1'b1, "R3 ti set after stop", ti, 1);
  endtask

  task automatic rx_send(input logic [7:0] d);
    @(negedge clk); rx_i = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      rx_i = d[b];
      repeat (BITC) @(negedge clk);
    end
    rx_i = 1'b1;
    repeat (BITC + 8) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk(tx_o === 1'b1, "R1 tx idle", tx_o, 1);
    chk(ti === 1'b0, "R1 ti", ti, 0);
    chk(ri === 1'b0, "R1 ri", ri, 0);
    rd(1'b0, v);
    chk(v === 8'h00, "R1 rx register", v, 0);
  endtask

  task automatic t_tx_basic;
    logic [7:0] v;
    wr(1'b0, 8'hA5);
    tx_frame(8'hA5, 1'b0, "R2 A5");
    rd(1'b1, v);
    chk(v === 8'h01, "R8 status ti only", v, 8'h01);
    rd(1'b0, v);
    chk(v === 8'h00, "R9 read not tx byte", v, 0);
    wr(1'b1, 8'h02);
    chk(ti === 1'b1, "R8 ri-clear leaves ti", ti, 1);
    wr(1'b1, 8'h01);
    chk(ti === 1'b0, "R8 ti cleared", ti, 0);
    wr(1'b0, 8'h01);
    tx_frame(8'h01, 1'b0, "R2 01");
    wr(1'b1, 8'h01);
  endtask

  task automatic t_tx_busy_write;
    bit stayed = 1'b1;
    wr(1'b0, 8'h80);
    tx_frame(8'h80, 1'b1, "R4 80");
    for (int i = 0; i < 3 * BITC; i++) begin
      @(negedge clk);
      if (tx_o !== 1'b1) stayed = 1'b0;
    end
    chk(stayed, "R4 no second frame", stayed, 1);
    wr(1'b1, 8'h01);
  endtask

  task automatic t_rx;
    logic [7:0] v;
    rx_send(8'h5A);
    chk(ri === 1'b1, "R5 ri set", ri, 1);
    rd(1'b0, v);
    chk(v === 8'h5A, "R5 byte 5A", v, 8'h5A);
    rd(1'b1, v);
    chk(v === 8'h02, "R8 status ri only", v, 8'h02);
    rx_send(8'hC3);
    rd(1'b0, v);
    chk(v === 8'h5A, "R7 overrun discarded", v, 8'h5A);
    chk(ri === 1'b1, "R7 ri still set", ri, 1);
    wr(1'b1, 8'h02);
    chk(ri === 1'b0, "R8 ri cleared", ri, 0);
    rd(1'b0, v);
    chk(v === 8'h5A, "R7 register not replaced", v, 8'h5A);
    rx_send(8'h7E);
    rd(1'b0, v);
    chk(v === 8'h7E, "R5 byte 7E", v, 8'h7E);
    wr(1'b1, 8'h02);
  endtask

  task automatic t_glitch;
    logic [7:0] v;
    @(negedge clk); rx_i = 1'b0;
    repeat (2 * TDIV) @(negedge clk);
    rx_i = 1'b1;
    repeat (12 * BITC) @(negedge clk);
    chk(ri === 1'b0, "R6 glitch no ri", ri, 0);
    rd(1'b0, v);
    chk(v === 8'h7E, "R6 register unchanged", v, 8'h7E);
  endtask

  initial begin
    #40000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_tx_basic();
    t_tx_busy_write();
    t_rx();
    t_glitch();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule